// File: doc/BRIEF.md
# Dual-Rate Waveform Playback Engine

This block plays two stored waveforms out to two 8-bit DAC words. Each channel owns a 256 x 8 sample memory and its own programmable rate divider. The fast channel uses an 8-bit divider and the slow channel a 16-bit one. Both channels share a single last-sample index, so each traces the same number of points per period. When the slow divide value is an integer multiple of the fast one, the slow waveform lasts exactly that many fast periods. With a 50 MHz clock, the fast output frequency is 50 MHz / ((fast divide + 1) x (last index + 1)).

The divide values and the last index are programmed as "value minus one". A host loads the sample memories through a plain write port, sets the three configuration inputs, and pulses the apply strobe. The apply strobe latches the configuration, clears both dividers and both read addresses, and starts playback. Both channels therefore begin phase-aligned. Each output sample is presented with a one-cycle valid pulse and is held until the next one.

Top module: `wfp_dual_player`

## Requirements
- R1: After reset, both valid outputs are 0 and both sample outputs are 0. Both stay that way until the first apply strobe.
- R2: The apply strobe does three things at once. It latches the fast divide F, the slow divide S and the last index L. It clears both dividers and both read addresses. It suppresses valid in the apply cycle itself. The first fast valid comes F+1 clocks after the apply edge and carries fast memory address 0.
- R3: The fast channel gives one valid pulse every F+1 clocks. With F = 0, valid is high on every clock.
- R4: The slow channel gives one valid pulse every S+1 clocks, where S is a full 16-bit value.
- R5: Each valid steps the read address by one. The address wraps to 0 after reaching L, so L = 255 plays all 256 entries and L = 0 repeats entry 0.
- R6: The fast waveform period is (F+1)(L+1) clocks and the slow period is (S+1)(L+1) clocks. When S+1 = N(F+1), the slow period is exactly N fast periods.
- R7: Changes on the configuration inputs without an apply strobe have no effect on the output timing or the output samples.
- R8: The sample output equals the memory word at the current read address. It is updated together with a one-cycle valid pulse and held unchanged between pulses.
- R9: A write with wr_en high stores wr_data at wr_addr in the memory chosen by wr_sel (0 = fast, 1 = slow). The other channel's memory is untouched.
- R10: Driving rst_n low clears both valid and sample outputs at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_fast_div | input | 8 | Fast divide ratio minus one |
| cfg_slow_div | input | 16 | Slow divide ratio minus one |
| cfg_last_idx | input | 8 | Number of points minus one |
| apply | input | 1 | Latch configuration and restart both channels |
| wr_en | input | 1 | Sample memory write enable |
| wr_sel | input | 1 | Memory select: 0 fast, 1 slow |
| wr_addr | input | 8 | Sample memory write address |
| wr_data | input | 8 | Sample memory write data |
| fast_sample | output | 8 | Fast channel DAC word |
| fast_valid | output | 1 | Fast channel new-sample pulse |
| slow_sample | output | 8 | Slow channel DAC word |
| slow_valid | output | 1 | Slow channel new-sample pulse |

## Verification
The range properties on the divider counts and on the read addresses assume two things. First, the latched terminal values change only in the same cycle that clears the counters, which holds because both are driven by apply. Second, the slow divide width is at least the fast divide width. The bench drives apply for exactly one cycle and writes the memories only while no playback check is running. It scrambles the configuration inputs right after every apply, so any leak of unlatched configuration shows up as a timing or sample mismatch. Reset is asserted mid-playback on a falling clock edge and released on a later falling edge, so the synchronised release never races the apply strobe.

// File: rtl/wfp_pkg.sv
package wfp_pkg;
  localparam int SAMPLE_W   = 8;
  localparam int ADDR_W     = 8;
  localparam int FAST_DIV_W = 8;
  localparam int SLOW_DIV_W = 16;
  localparam int NUM_CH     = 2;

  typedef enum logic [0:0] {
    CH_FAST = 1'b0,
    CH_SLOW = 1'b1
  } chan_e;
endpackage

// File: rtl/wfp_rate_div.sv
module wfp_rate_div #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic         clear_i,
  input  logic [W-1:0] term_i,
  output logic         step_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;
  logic         at_term;

  always_comb begin
    at_term = (cnt_q == term_i);
    cnt_en  = clear_i | run_i;
    cnt_d   = cnt_q;
    if (clear_i)      cnt_d = '0;
    else if (at_term) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
    step_o  = run_i & ~clear_i & at_term;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R3 / R4: count never passes the latched terminal value
  p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !clear_i) |-> (cnt_q <= term_i));

  // R2: a clear restarts the divider phase
  p_clear_zeroes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cnt_q == '0));
endmodule

// File: rtl/wfp_sample_ram.sv
module wfp_sample_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_q <= '0;
    else if (re_i) rdata_q <= mem_q[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/wfp_channel.sv
module wfp_channel #(
  parameter int DIV_W = 8,
  parameter int AW    = 8,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             clear_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [AW-1:0]    last_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    sample_o,
  output logic             valid_o
);
  logic          step;
  logic [AW-1:0] addr_q, addr_d;
  logic          addr_en;
  logic          valid_q;

  wfp_rate_div #(.W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (run_i),
    .clear_i (clear_i),
    .term_i  (div_i),
    .step_o  (step)
  );

  always_comb begin
    addr_en = clear_i | step;
    addr_d  = addr_q;
    if (clear_i)               addr_d = '0;
    else if (addr_q == last_i) addr_d = '0;
    else                       addr_d = addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= step;
  end

  wfp_sample_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (we_i),
    .waddr_i (waddr_i),
    .wdata_i (wdata_i),
    .re_i    (step),
    .raddr_i (addr_q),
    .rdata_o (sample_o)
  );

  assign valid_o = valid_q;

  // R5: read address stays within the programmed point count
  p_addr_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !clear_i) |-> (addr_q <= last_i));

  // R8: every divider step yields exactly one valid in the next cycle
  p_valid_after_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> valid_o);

  p_valid_needs_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(step));

  // R8: the DAC word holds between valid pulses
  p_sample_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(sample_o));
endmodule

// File: rtl/wfp_dual_player.sv
module wfp_dual_player
  import wfp_pkg::*;
#(
  parameter int SW  = SAMPLE_W,
  parameter int AW  = ADDR_W,
  parameter int FDW = FAST_DIV_W,
  parameter int SDW = SLOW_DIV_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [FDW-1:0] cfg_fast_div,
  input  logic [SDW-1:0] cfg_slow_div,
  input  logic [AW-1:0]  cfg_last_idx,
  input  logic           apply,
  input  logic           wr_en,
  input  logic           wr_sel,
  input  logic [AW-1:0]  wr_addr,
  input  logic [SW-1:0]  wr_data,
  output logic [SW-1:0]  fast_sample,
  output logic           fast_valid,
  output logic [SW-1:0]  slow_sample,
  output logic           slow_valid
);
  localparam int MAXW = (SDW > FDW) ? SDW : FDW;

  logic [1:0]     rst_pipe;
  logic           rst_s;
  logic [FDW-1:0] fast_div_q;
  logic [SDW-1:0] slow_div_q;
  logic [AW-1:0]  last_q;
  logic           run_q;

  logic [MAXW-1:0] div_arr    [NUM_CH];
  logic [SW-1:0]   sample_arr [NUM_CH];
  logic            valid_arr  [NUM_CH];

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  // configuration shadow, loaded only on apply
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      fast_div_q <= '0;
      slow_div_q <= '0;
      last_q     <= '0;
    end else if (apply) begin
      fast_div_q <= cfg_fast_div;
      slow_div_q <= cfg_slow_div;
      last_q     <= cfg_last_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)     run_q <= 1'b0;
    else if (apply) run_q <= 1'b1;
  end

  assign div_arr[CH_FAST] = MAXW'(fast_div_q);
  assign div_arr[CH_SLOW] = MAXW'(slow_div_q);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int DWG = (g == int'(CH_FAST)) ? FDW : SDW;
    logic ch_we;
    assign ch_we = wr_en & (wr_sel == g[0]);

    wfp_channel #(.DIV_W(DWG), .AW(AW), .DW(SW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_s),
      .run_i    (run_q),
      .clear_i  (apply),
      .div_i    (div_arr[g][DWG-1:0]),
      .last_i   (last_q),
      .we_i     (ch_we),
      .waddr_i  (wr_addr),
      .wdata_i  (wr_data),
      .sample_o (sample_arr[g]),
      .valid_o  (valid_arr[g])
    );
  end

  assign fast_sample = sample_arr[CH_FAST];
  assign fast_valid  = valid_arr[CH_FAST];
  assign slow_sample = sample_arr[CH_SLOW];
  assign slow_valid  = valid_arr[CH_SLOW];

  // R1: nothing is emitted before the first apply
  p_idle_until_apply_r1: assert property (@(posedge clk) disable iff (!rst_s)
    !run_q |-> (!fast_valid && !slow_valid));

  // R7: latched configuration moves only on apply
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_s)
    !apply |=> ($stable(fast_div_q) && $stable(slow_div_q) && $stable(last_q)));

  // R2: no valid in the cycle right after an apply
  p_apply_quiet_r2: assert property (@(posedge clk) disable iff (!rst_s)
    apply |=> (!fast_valid && !slow_valid));
endmodule

// File: tb/wfp_dual_player_bench.sv
module wfp_dual_player_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  cfg_fast_div;
  logic [15:0] cfg_slow_div;
  logic [7:0]  cfg_last_idx;
  logic        apply;
  logic        wr_en;
  logic        wr_sel;
  logic [7:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [7:0]  fast_sample;
  logic        fast_valid;
  logic [7:0]  slow_sample;
  logic        slow_valid;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;
  logic [7:0] mdl [2][256];

  always #5 clk = ~clk;

  wfp_dual_player u_wfp_dual_player (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_fast_div (cfg_fast_div),
    .cfg_slow_div (cfg_slow_div),
    .cfg_last_idx (cfg_last_idx),
    .apply        (apply),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .fast_sample  (fast_sample),
    .fast_valid   (fast_valid),
    .slow_sample  (slow_sample),
    .slow_valid   (slow_valid)
  );

  // {fast divide, slow divide, last index}
  localparam logic [31:0] VEC [6] = '{
    {8'd0, 16'd19,  8'd3},
    {8'd2, 16'd59,  8'd7},
    {8'd1, 16'd3,   8'd0},
    {8'd4, 16'd9,   8'd255},
    {8'd0, 16'd299, 8'd1},
    {8'd7, 16'd15,  8'd4}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic mem_write(input int sel, input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel[0]; wr_addr = addr[7:0]; wr_data = data[7:0];
    mdl[sel][addr] = data[7:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic apply_cfg(input int f, input int s, input int l);
    @(negedge clk);
    cfg_fast_div = f[7:0]; cfg_slow_div = s[15:0]; cfg_last_idx = l[7:0];
    apply = 1'b1;
    @(negedge clk);
    apply = 1'b0;
    // R7: scramble the inputs; the latched values must keep ruling
    cfg_fast_div = ~f[7:0]; cfg_slow_div = ~s[15:0]; cfg_last_idx = ~l[7:0];
  endtask

  // called at the first falling edge after the apply edge (m = 0)
  task automatic play_check(input int f, input int s, input int l, input int cycles,
                            input string stag);
    int  d [2];
    int  last0 [2];
    int  per [2];
    bit  have [2];
    int  exps [2];
    d[0] = f; d[1] = s;
    for (int c = 0; c < 2; c++) begin
      last0[c] = -1; per[c] = -1; have[c] = 1'b0; exps[c] = 0;
    end
    for (int m = 0; m < cycles; m++) begin
      for (int c = 0; c < 2; c++) begin
        bit   ev;
        int   idx;
        logic v;
        logic [7:0] smp;
        v   = (c == 0) ? fast_valid : slow_valid;
        smp = (c == 0) ? fast_sample : slow_sample;
        ev  = (m > 0) && (m % (d[c] + 1) == 0);
        idx = 0;
        if (ev) begin
          idx = (m / (d[c] + 1) - 1) % (l + 1);
          exps[c] = mdl[c][idx];
          have[c] = 1'b1;
        end
        // R2 first step timing, R3 fast rate, R4 slow rate
        check(v == ev, (c == 0) ? "R3 fast valid" : "R4 slow valid", int'(v), int'(ev));
        // R5 wrap order / R8 hold between pulses
        if (have[c]) check(smp == exps[c][7:0], stag, int'(smp), exps[c]);
        if (ev && idx == 0) begin
          if (last0[c] >= 0) begin
            per[c] = m - last0[c];
            check(per[c] == (d[c] + 1) * (l + 1), "R6 period", per[c], (d[c] + 1) * (l + 1));
          end
          last0[c] = m;
        end
      end
      @(negedge clk);
    end
    if (((s + 1) % (f + 1)) == 0 && per[0] > 0 && per[1] > 0)
      check(per[1] == ((s + 1) / (f + 1)) * per[0], "R6 ratio", per[1],
            ((s + 1) / (f + 1)) * per[0]);
  endtask

  task automatic run_vec(input int f, input int s, input int l, input string stag);
    apply_cfg(f, s, l);
    play_check(f, s, l, (s + 1) * (l + 2) + 2, stag);
  endtask

  initial begin
    rst_n = 1'b0; apply = 1'b0; wr_en = 1'b0; wr_sel = 1'b0;
    wr_addr = '0; wr_data = '0;
    cfg_fast_div = '0; cfg_slow_div = '0; cfg_last_idx = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(fast_valid == 1'b0 && slow_valid == 1'b0, "R1 valid in reset", int'(fast_valid | slow_valid), 0);
    check(fast_sample == 8'd0 && slow_sample == 8'd0, "R1 sample in reset", int'(fast_sample | slow_sample), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 256; i++) begin
      mem_write(0, i, (i * 7 + 3) & 255);
      mem_write(1, i, i ^ 8'h5A);
    end
    // R1: still idle without an apply
    check(fast_valid == 1'b0 && slow_valid == 1'b0, "R1 idle before apply", int'(fast_valid | slow_valid), 0);
    check(fast_sample == 8'd0 && slow_sample == 8'd0, "R1 sample before apply", int'(fast_sample | slow_sample), 0);

    // vector table; each apply also restarts a running player (R2)
    for (int i = 0; i < 6; i++)
      run_vec(int'(VEC[i][31:24]), int'(VEC[i][23:8]), int'(VEC[i][7:0]), "R5 sample");

    // R9: write only the fast memory, slow contents must stay as modelled
    mem_write(0, 0, 8'hC3);
    mem_write(0, 1, 8'h3C);
    run_vec(3, 7, 1, "R9 sample");

    // R10: asynchronous clear mid-playback
    apply_cfg(0, 2, 5);
    repeat (13) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(fast_valid == 1'b0 && slow_valid == 1'b0, "R10 valid", int'(fast_valid | slow_valid), 0);
    check(fast_sample == 8'd0 && slow_sample == 8'd0, "R10 sample", int'(fast_sample | slow_sample), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check(fast_valid == 1'b0 && slow_valid == 1'b0, "R1 idle after reset", int'(fast_valid | slow_valid), 0);
    end
    // recovery after reset, memory contents retained
    run_vec(2, 5, 2, "R8 sample");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule